// File: doc/BRIEF.md
# Exception Return Sequencing Controller

This block runs when an interrupt service routine finishes. On an exit request it compares the highest pending exception with the highest stacked (preempted) exception and picks one of three exits. It can tail-chain straight into the pending handler. It can unstack back into the most recently preempted handler. Or it can unstack back to thread-level code.

A tail-chain skips memory entirely. The block raises a request to the entry logic and finishes when that logic acknowledges. Both unstacking exits read an eight-word frame through a simple read port, one word at a time in ascending address order. When the frame has been read, the block publishes four results: the return PC, the new stack pointer value, the active exception number taken from the status word, and the stack-pointer selection.

The decision is taken once, in the cycle the exit request is seen. Pending inputs that change later do not alter that exit.

Top module: `exc_return_ctrl`

## Requirements
- R1: On `exit_req`, a tail-chain is chosen when an exception is pending and either nothing is stacked or the pending priority value is strictly lower (more urgent) than the stacked one. The chain raises `chain_req` and issues no memory read.
- R2: A tail-chain completes one cycle after `chain_ack` is seen. At that point `exit_done` pulses with `exit_path` = 1, `active_num` equals the pending number sampled at the decision, `sp_sel` = 0 and `sp_out` equals `sp_in` sampled at the decision.
- R3: When something is stacked and the pending exception does not strictly outrank it, the exit returns into the stacked handler. This covers an equal priority and the case where nothing is pending. It ends with `exit_path` = 2.
- R4: With nothing pending and nothing stacked, the exit returns to thread code. It ends with `exit_path` = 3.
- R5: An unstacking exit reads exactly eight words at addresses `sp_in`+0, +4, … +28, in rising order. Each read is held on `mem_rd_req`, and `mem_rd_addr` stays stable until `mem_rd_valid` is high at a clock edge.
- R6: After an unstack, `ret_pc` equals the seventh word read (offset 24), and `sp_out` equals `sp_in` + 32.
- R7: After an unstack, `active_num` equals bits [NUM_W-1:0] of the eighth word read (offset 28, the status word).
- R8: After a handler return `sp_sel` is 0 (main stack). After a thread return `sp_sel` equals `thread_psp` sampled with `exit_req`.
- R9: Changes to the pending or stacked inputs after the exit request has been accepted do not change the path or the results of that exit.
- R10: `exit_done` is high for exactly one cycle per exit. After reset, `exit_done`, `chain_req`, `mem_rd_req`, `exit_path`, `active_num` and `sp_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exit_req | input | 1 | Handler finished; accepted while idle |
| pend_valid | input | 1 | A pending exception exists |
| pend_prio | input | PRIO_W | Priority value of the highest pending exception (lower is more urgent) |
| pend_num | input | NUM_W | Exception number of the highest pending exception |
| stk_valid | input | 1 | At least one exception is stacked |
| stk_prio | input | PRIO_W | Priority value of the highest stacked exception |
| thread_psp | input | 1 | Stack selection for thread return, recorded at entry (1 = process stack) |
| sp_in | input | ADDR_W | Current stack pointer, frame base |
| chain_ack | input | 1 | Entry logic accepted the tail-chain |
| mem_rd_valid | input | 1 | Read data valid; the read is accepted at this edge |
| mem_rd_data | input | DATA_W | Read data |
| chain_req | output | 1 | Tail-chain request to the entry logic |
| mem_rd_req | output | 1 | Read request |
| mem_rd_addr | output | ADDR_W | Read address |
| exit_done | output | 1 | One-cycle completion pulse |
| exit_path | output | 2 | 1 chain, 2 handler return, 3 thread return |
| ret_pc | output | DATA_W | Restored program counter |
| sp_out | output | ADDR_W | Stack pointer after the exit |
| sp_sel | output | 1 | 0 main stack, 1 process stack |
| active_num | output | NUM_W | New active exception number |

## Verification
Directed cases separate the three exits at their boundaries. They cover a pending exception with nothing stacked, a pending exception one level more urgent than the stacked one, an exact tie, nothing pending with something stacked, and an empty state with both settings of the thread stack bit. The tie case is what tells a strict comparison from a non-strict one. Random priorities drawn from a narrow range make ties and near ties frequent. Random read stalls and late rewrites of the pending inputs show that the frame order, the captured PC and status, and the path stay fixed once an exit has started.

// File: rtl/exc_ret_pkg.sv
package exc_ret_pkg;
  typedef enum logic [1:0] {
    PATH_NONE    = 2'd0,
    PATH_CHAIN   = 2'd1,
    PATH_HANDLER = 2'd2,
    PATH_THREAD  = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHAIN = 2'd1,
    ST_POP   = 2'd2
  } state_e;
endpackage

// File: rtl/exc_ret_decide.sv
module exc_ret_decide
  import exc_ret_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              stk_valid,
  input  logic [PRIO_W-1:0] stk_prio,
  output path_e             path
);
  logic pend_wins;

  // strict compare: equal urgency stays with the stacked handler
  assign pend_wins = pend_valid && (!stk_valid || (pend_prio < stk_prio));

  always_comb begin
    if (pend_wins)      path = PATH_CHAIN;
    else if (stk_valid) path = PATH_HANDLER;
    else                path = PATH_THREAD;
  end
endmodule

// File: rtl/exc_ret_unstack.sv
module exc_ret_unstack #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [DATA_W-1:0] pc_word,
  output logic              last
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int PC_IDX = WORDS - 2;

  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q;
  logic              accept;

  assign accept      = busy && mem_rd_valid;
  assign last        = accept && (idx == IDX_W'(WORDS - 1));
  assign mem_rd_req  = busy;
  assign mem_rd_addr = base_q + ADDR_W'({idx, 2'b00});

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx     <= '0;
      base_q  <= '0;
      pc_word <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      idx    <= '0;
      base_q <= base;
    end else if (accept) begin
      if (idx == IDX_W'(PC_IDX)) pc_word <= mem_rd_data;
      if (last) busy <= 1'b0;
      else      idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/exc_return_ctrl.sv
module exc_return_ctrl
  import exc_ret_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int NUM_W  = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exit_req,
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [NUM_W-1:0]  pend_num,
  input  logic              stk_valid,
  input  logic [PRIO_W-1:0] stk_prio,
  input  logic              thread_psp,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic              chain_ack,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              chain_req,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              exit_done,
  output logic [1:0]        exit_path,
  output logic [DATA_W-1:0] ret_pc,
  output logic [ADDR_W-1:0] sp_out,
  output logic              sp_sel,
  output logic [NUM_W-1:0]  active_num
);
  localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(WORDS * 4);

  state_e            state;
  path_e             path_now, path_q;
  logic              cfg_q;
  logic [ADDR_W-1:0] sp_q;
  logic [NUM_W-1:0]  pnum_q;
  logic              accept_exit, pop_start, pop_last;
  logic [DATA_W-1:0] pc_word;

  exc_ret_decide #(.PRIO_W(PRIO_W)) i_decide (
    .pend_valid (pend_valid),
    .pend_prio  (pend_prio),
    .stk_valid  (stk_valid),
    .stk_prio   (stk_prio),
    .path       (path_now)
  );

  assign accept_exit = (state == ST_IDLE) && exit_req;
  assign pop_start   = accept_exit && (path_now != PATH_CHAIN);

  exc_ret_unstack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) i_unstack (
    .clk          (clk),
    .rst          (rst),
    .start        (pop_start),
    .base         (sp_in),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .pc_word      (pc_word),
    .last         (pop_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      path_q     <= PATH_NONE;
      cfg_q      <= 1'b0;
      sp_q       <= '0;
      pnum_q     <= '0;
      chain_req  <= 1'b0;
      exit_done  <= 1'b0;
      exit_path  <= 2'd0;
      ret_pc     <= '0;
      sp_out     <= '0;
      sp_sel     <= 1'b0;
      active_num <= '0;
    end else begin
      exit_done <= 1'b0;
      unique case (state)
        ST_IDLE: if (exit_req) begin
          path_q <= path_now;
          cfg_q  <= thread_psp;
          sp_q   <= sp_in;
          pnum_q <= pend_num;
          if (path_now == PATH_CHAIN) begin
            chain_req <= 1'b1;
            state     <= ST_CHAIN;
          end else begin
            state <= ST_POP;
          end
        end
        ST_CHAIN: if (chain_ack) begin
          chain_req  <= 1'b0;
          exit_done  <= 1'b1;
          exit_path  <= PATH_CHAIN;
          active_num <= pnum_q;
          sp_sel     <= 1'b0;
          sp_out     <= sp_q;
          state      <= ST_IDLE;
        end
        ST_POP: if (pop_last) begin
          exit_done  <= 1'b1;
          exit_path  <= path_q;
          ret_pc     <= pc_word;
          active_num <= mem_rd_data[NUM_W-1:0];
          sp_sel     <= (path_q == PATH_THREAD) ? cfg_q : 1'b0;
          sp_out     <= sp_q + FRAME_BYTES;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_ret_checker.sv
module exc_ret_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              chain_req,
  input logic              chain_ack,
  input logic              mem_rd_req,
  input logic              mem_rd_valid,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              exit_done,
  input logic [1:0]        exit_path,
  input logic              sp_sel
);
  p_chain_no_read_r1: assert property (@(posedge clk) disable iff (rst)
    chain_req |-> !mem_rd_req);

  p_chain_after_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (exit_done && exit_path == 2'd1) |-> $past(chain_ack));

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && mem_rd_valid) |=>
      (!mem_rd_req || mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(4)));

  p_handler_main_r8: assert property (@(posedge clk) disable iff (rst)
    (exit_done && exit_path == 2'd2) |-> !sp_sel);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    exit_done |=> !exit_done);

  p_done_path_r10: assert property (@(posedge clk) disable iff (rst)
    exit_done |-> (exit_path != 2'd0));
endmodule

bind exc_return_ctrl exc_ret_checker #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_exc_return_ctrl.sv
module test_exc_return_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PRIO_W = 3;
  localparam int NUM_W  = 6;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic exit_req = 0, pend_valid = 0, stk_valid = 0, thread_psp = 0, chain_ack = 0;
  logic mem_rd_valid = 0;
  logic [PRIO_W-1:0] pend_prio = 0, stk_prio = 0;
  logic [NUM_W-1:0]  pend_num = 0;
  logic [ADDR_W-1:0] sp_in = 0;
  logic [DATA_W-1:0] mem_rd_data;
  logic chain_req, mem_rd_req, exit_done, sp_sel;
  logic [ADDR_W-1:0] mem_rd_addr, sp_out;
  logic [1:0] exit_path;
  logic [DATA_W-1:0] ret_pc;
  logic [NUM_W-1:0] active_num;

  int tests = 0, fails = 0, rd_cnt = 0;
  logic [ADDR_W-1:0] exp_base = 0;
  bit stall_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_return_ctrl i_exc_return_ctrl (.*);

  function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic int exp_path(input bit pv, input logic [PRIO_W-1:0] pp,
                                  input bit sv, input logic [PRIO_W-1:0] spr);
    if (pv && (!sv || pp < spr)) return 1;
    if (sv) return 2;
    return 3;
  endfunction

  assign mem_rd_data = word_at(mem_rd_addr);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // read stalls driven just after the edge
  always @(posedge clk) begin
    #1;
    mem_rd_valid = stall_mode ? ($urandom % 3 == 0) : 1'b1;
  end

  // entry logic model for tail-chain
  always @(negedge clk) chain_ack <= chain_req && ($urandom % 2 == 1);

  // frame order check at each accepted read (R5)
  always @(negedge clk) begin
    if (!rst && mem_rd_req && mem_rd_valid) begin
      check("R5 addr", mem_rd_addr, exp_base + 32'(rd_cnt * 4));
      rd_cnt++;
    end
  end

  task automatic run_exit(input bit pv, input logic [PRIO_W-1:0] pp, input logic [NUM_W-1:0] pn,
                          input bit sv, input logic [PRIO_W-1:0] spr, input bit cfg,
                          input logic [ADDR_W-1:0] base);
    int ep, waited;
    ep = exp_path(pv, pp, sv, spr);
    @(negedge clk);
    pend_valid = pv; pend_prio = pp; pend_num = pn;
    stk_valid = sv; stk_prio = spr; thread_psp = cfg; sp_in = base;
    exp_base = base; rd_cnt = 0;
    exit_req = 1;
    @(negedge clk);
    exit_req = 0;
    // R9: late changes must not alter this exit
    pend_valid = 1; pend_prio = 0; pend_num = ~pn; stk_valid = ~sv;
    thread_psp = ~cfg; sp_in = ~base;
    waited = 0;
    while (!exit_done && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    check("R10 done seen", exit_done, 1);
    check("R1 R3 R4 R9 path", exit_path, ep);
    if (ep == 1) begin
      check("R1 no reads", rd_cnt, 0);
      check("R2 active", active_num, pn);
      check("R2 sp_out", sp_out, base);
      check("R2 sp_sel", sp_sel, 0);
    end else begin
      check("R5 count", rd_cnt, 8);
      check("R6 ret_pc", ret_pc, word_at(base + 24));
      check("R6 sp_out", sp_out, base + 32);
      check("R7 active", active_num, word_at(base + 28) & 32'h3F);
      check("R8 sp_sel", sp_sel, (ep == 3) ? cfg : 1'b0);
    end
    @(negedge clk);
    check("R10 pulse", exit_done, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check("R10 rst done", exit_done, 0);
    check("R10 rst chain_req", chain_req, 0);
    check("R10 rst rd_req", mem_rd_req, 0);
    check("R10 rst path", exit_path, 0);
    check("R10 rst active", active_num, 0);
    check("R10 rst sp_sel", sp_sel, 0);

    // directed corners
    run_exit(1, 3'd4, 6'd17, 0, 3'd0, 0, 32'h2000_0100); // R1 nothing stacked
    run_exit(1, 3'd2, 6'd9,  1, 3'd3, 1, 32'h2000_0200); // R1 one level more urgent
    run_exit(1, 3'd3, 6'd9,  1, 3'd3, 1, 32'h2000_0300); // R3 tie
    run_exit(0, 3'd0, 6'd5,  1, 3'd6, 1, 32'h2000_0400); // R3 nothing pending
    run_exit(1, 3'd5, 6'd5,  1, 3'd1, 0, 32'h2000_0500); // R3 stacked outranks
    run_exit(0, 3'd0, 6'd0,  0, 3'd0, 0, 32'h2000_0600); // R4 cfg 0
    run_exit(0, 3'd0, 6'd0,  0, 3'd0, 1, 32'h2000_0700); // R4 R8 cfg 1
    stall_mode = 1;
    run_exit(0, 3'd0, 6'd0,  1, 3'd2, 0, 32'h2000_0800); // R5 with stalls

    // random mix
    for (int i = 0; i < 60; i++) begin
      stall_mode = ($urandom % 2 == 1);
      run_exit($urandom % 2 == 1, 3'($urandom % 4), 6'($urandom),
               $urandom % 2 == 1, 3'($urandom % 4), $urandom % 2 == 1,
               {$urandom(), 2'b00} >> 0 & 32'hFFFF_FFFC);
    end
    summary();
  end
endmodule